// File: doc/BRIEF.md
# Indexed Palette DAC Register Port

This block is the host side of a 256-entry colour lookup table. Software reaches it through one 32-bit register word that is split into four byte lanes. One lane sets where the next colour is written, one sets where the next colour is read, one holds a pixel mask, and one is a data port. A colour is moved one byte at a time, red first, then green, then blue.

A single three-state component counter is shared by reads and writes. It picks which colour byte the next data access touches. It advances on every data access, and it falls back to red whenever either index lane is written. Written bytes are ANDed with the mask and gathered in a holding buffer. The third write commits the whole triple to the table. A data read at the red phase loads the full entry into the same holding buffer, so the green and blue reads that follow come from a stable copy.

A second, independent read port serves the pixel pipeline. It has one cycle of latency.

Top module: `palette_dac_port`

## Requirements
- R1: The host word has four byte lanes: bits [7:0] are the write index, [15:8] the data port, [23:16] the mask and [31:24] the read index. In a write, `wr_be[n]` enables lane n. The host issues at most one of `wr_en` and `rd_en` in any cycle.
- R2: `rd_data` is registered and appears one cycle after `rd_en`. Each enabled lane returns its value: lane 0 gives the write index, lane 2 the mask and lane 3 the read index. Lanes whose `rd_be` bit is clear return zero.
- R3: A write that enables lane 0 or lane 3 loads that index and returns the component counter to red. If the data lane is enabled in that same write, it is ignored.
- R4: A data write stores the data byte ANDed with the current mask into the component selected by the counter (0 = red, 1 = green, 2 = blue), then advances the counter.
- R5: The blue data write stores the held red, the held green and the masked blue byte at the write index. The write index then increments and the counter returns to red.
- R6: A data read at the red phase fetches the whole entry at the read index. Each data read returns, on lane 1, the component that the counter selects, in red, green, blue order.
- R7: The blue data read increments the read index and returns the counter to red.
- R8: Both indices wrap from 255 to 0.
- R9: `pix_rgb` gives the entry at `pix_idx` one cycle later, packed as {red, green, blue}. Host accesses and the mask do not affect it.
- R10: Reset (synchronous, active high) clears both indices, sets the mask to 0xFF and sets the counter to red.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 4 | Lane enables for the write |
| wr_data | input | 32 | Host write word |
| rd_en | input | 1 | Host read strobe |
| rd_be | input | 4 | Lane enables for the read |
| rd_data | output | 32 | Registered host read word |
| pix_idx | input | 8 | Pixel lookup index |
| pix_rgb | output | 24 | Looked-up colour {r,g,b}, one cycle later |

## Verification
The assertions assume the host never raises a write and a read in the same cycle. They also assume no write is issued while reset is held. The bench drives every host access through one task at a time, and a strobe lasts exactly one cycle, so no two accesses overlap. The index advance and counter restart checks rely on this: with only one access per cycle, each change of the counter has a single cause.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int IDX_W     = 8;
    localparam int COMP_W    = 8;
    localparam int LANE_W    = 8;
    localparam int LANES     = 4;
    localparam int WORD_W    = LANE_W * LANES;
    localparam int RGB_W     = 3 * COMP_W;

    localparam int LANE_WIDX = 0;
    localparam int LANE_DATA = 1;
    localparam int LANE_MASK = 2;
    localparam int LANE_RIDX = 3;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [COMP_W-1:0] comp_t;

    typedef struct packed {
        comp_t r;
        comp_t g;
        comp_t b;
    } rgb_t;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

    function automatic comp_t comp_of(rgb_t e, phase_e p);
        case (p)
            PH_RED:   return e.r;
            PH_GREEN: return e.g;
            default:  return e.b;
        endcase
    endfunction

    function automatic rgb_t with_comp(rgb_t e, phase_e p, comp_t v);
        rgb_t n;
        n = e;
        case (p)
            PH_RED:   n.r = v;
            PH_GREEN: n.g = v;
            default:  n.b = v;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pal_ram.sv
module pal_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] haddr,
    output logic [DW-1:0] hdata,
    input  logic [AW-1:0] pix_addr,
    output logic [DW-1:0] pix_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // host port: combinational, the controller registers what it needs
    assign hdata = mem[haddr];

    // pixel port: one register stage
    always_ff @(posedge clk) begin
        pix_data <= mem[pix_addr];
    end

    AST_PIX_STEADY: assert property (@(posedge clk) disable iff (rst)
        (pix_addr == $past(pix_addr) && !$past(we)) |=> $stable(pix_data)); // R9
endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [LANES-1:0]  rd_be,
    input  rgb_t              ram_rdata,
    output logic              ram_we,
    output idx_t              ram_waddr,
    output rgb_t              ram_wdata,
    output idx_t              ram_raddr,
    output logic [WORD_W-1:0] rd_data
);
    idx_t   wr_idx_q;
    idx_t   rd_idx_q;
    comp_t  mask_q;
    phase_e phase_q;
    rgb_t   hold_q;

    logic   idx_wr;
    logic   data_wr;
    logic   data_rd;
    logic   last_ph;
    comp_t  wr_byte;
    rgb_t   cur_entry;
    comp_t  rd_comp;
    logic [WORD_W-1:0] lane_vals;

    always_comb begin
        idx_wr    = wr_en && (wr_be[LANE_WIDX] || wr_be[LANE_RIDX]);
        data_wr   = wr_en && wr_be[LANE_DATA] && !idx_wr;
        data_rd   = rd_en && rd_be[LANE_DATA];
        last_ph   = (phase_q == PH_BLUE);
        wr_byte   = comp_t'(wr_data[LANE_DATA*LANE_W +: LANE_W]) & mask_q;
        cur_entry = (phase_q == PH_RED) ? ram_rdata : hold_q;
        rd_comp   = comp_of(cur_entry, phase_q);
    end

    always_comb begin
        lane_vals = '0;
        lane_vals[LANE_WIDX*LANE_W +: LANE_W] = LANE_W'(wr_idx_q);
        lane_vals[LANE_DATA*LANE_W +: LANE_W] = LANE_W'(rd_comp);
        lane_vals[LANE_MASK*LANE_W +: LANE_W] = LANE_W'(mask_q);
        lane_vals[LANE_RIDX*LANE_W +: LANE_W] = LANE_W'(rd_idx_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx_q <= '0;
            rd_idx_q <= '0;
            mask_q   <= '1;
            phase_q  <= PH_RED;
            hold_q   <= '0;
        end else begin
            if (wr_en && wr_be[LANE_WIDX]) wr_idx_q <= idx_t'(wr_data[LANE_WIDX*LANE_W +: LANE_W]);
            if (wr_en && wr_be[LANE_MASK]) mask_q   <= comp_t'(wr_data[LANE_MASK*LANE_W +: LANE_W]);
            if (wr_en && wr_be[LANE_RIDX]) rd_idx_q <= idx_t'(wr_data[LANE_RIDX*LANE_W +: LANE_W]);

            if (idx_wr) begin
                phase_q <= PH_RED;
            end else if (data_wr) begin
                hold_q  <= with_comp(hold_q, phase_q, wr_byte);
                phase_q <= phase_after(phase_q);
                if (last_ph) wr_idx_q <= wr_idx_q + 1'b1;
            end else if (data_rd) begin
                if (phase_q == PH_RED) hold_q <= ram_rdata;
                phase_q <= phase_after(phase_q);
                if (last_ph) rd_idx_q <= rd_idx_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            for (int l = 0; l < LANES; l++) begin
                rd_data[l*LANE_W +: LANE_W] <= rd_be[l] ? lane_vals[l*LANE_W +: LANE_W] : '0;
            end
        end
    end

    always_comb begin
        ram_we    = data_wr && last_ph;
        ram_waddr = wr_idx_q;
        ram_wdata = '{r: hold_q.r, g: hold_q.g, b: wr_byte};
        ram_raddr = rd_idx_q;
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && rd_en)); // R1
    AST_INDEX_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        idx_wr |=> (phase_q == PH_RED)); // R3
    AST_MASKED_RED: assert property (@(posedge clk) disable iff (rst)
        (data_wr && phase_q == PH_RED) |=> ((hold_q.r & ~$past(mask_q)) == '0)); // R4
    AST_WRITE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (data_wr && last_ph) |=> (wr_idx_q == idx_t'($past(wr_idx_q) + 1'b1) && phase_q == PH_RED)); // R5
    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (data_rd && last_ph) |=> (rd_idx_q == idx_t'($past(rd_idx_q) + 1'b1) && phase_q == PH_RED)); // R7
    AST_WIDX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(wr_idx_q)); // R5
endmodule

// File: rtl/palette_dac_port.sv
module palette_dac_port
    import pal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [3:0]        rd_be,
    output logic [31:0]       rd_data,
    input  logic [7:0]        pix_idx,
    output logic [23:0]       pix_rgb
);
    logic ram_we;
    idx_t ram_waddr;
    rgb_t ram_wdata;
    idx_t ram_raddr;
    rgb_t ram_rdata;

    pal_ctrl i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_be     (wr_be),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_be     (rd_be),
        .ram_rdata (ram_rdata),
        .ram_we    (ram_we),
        .ram_waddr (ram_waddr),
        .ram_wdata (ram_wdata),
        .ram_raddr (ram_raddr),
        .rd_data   (rd_data)
    );

    pal_ram #(.AW(IDX_W), .DW(RGB_W)) i_ram (
        .clk      (clk),
        .rst      (rst),
        .we       (ram_we),
        .waddr    (ram_waddr),
        .wdata    (ram_wdata),
        .haddr    (ram_raddr),
        .hdata    (ram_rdata),
        .pix_addr (pix_idx),
        .pix_data (pix_rgb)
    );
endmodule

// File: tb/test_palette_dac_port.sv
`timescale 1ns/1ps
module test_palette_dac_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_be = '0;
    logic [31:0] rd_data;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [23:0] model [256];

    always #4 clk = ~clk;

    palette_dac_port i_palette_dac_port (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_en(rd_en), .rd_be(rd_be), .rd_data(rd_data),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    function automatic logic [23:0] pattern(int i);
        logic [7:0] r, g, b;
        r = 8'(i);
        g = 8'(i * 7 + 3);
        b = 8'(i) ^ 8'hA5;
        return {r, g, b};
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic hw(logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic hr(logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_be = be;
        @(negedge clk);
        rd_en = 1'b0; rd_be = '0;
        d = rd_data;
    endtask

    task automatic wdata(logic [7:0] b);
        hw(4'b0010, {16'h0, b, 8'h0});
    endtask

    task automatic rcomp(output logic [7:0] b);
        logic [31:0] d;
        hr(4'b0010, d);
        b = d[15:8];
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic [7:0] c;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state, R2 lanes with data lane disabled read zero
        hr(4'b1101, d);
        check(d == 32'h00FF_0000, "R10", d, 32'h00FF_0000);

        // R5 R8: sweep all entries through the data port starting at 0
        hw(4'b0001, 32'h0);
        for (int i = 0; i < 256; i++) begin
            model[i] = pattern(i);
            wdata(model[i][23:16]);
            wdata(model[i][15:8]);
            wdata(model[i][7:0]);
            hr(4'b0001, d);
            check(d == 32'((i + 1) % 256), "R5", d, 32'((i + 1) % 256));
        end
        hr(4'b0001, d);
        check(d == 32'h0, "R8", d, 32'h0);

        // R6 R7 R8: read back the whole table
        hw(4'b1000, 32'h0);
        for (int i = 0; i < 256; i++) begin
            rcomp(c); check(c == model[i][23:16], "R6", 32'(c), 32'(model[i][23:16]));
            rcomp(c); check(c == model[i][15:8],  "R6", 32'(c), 32'(model[i][15:8]));
            rcomp(c); check(c == model[i][7:0],   "R6", 32'(c), 32'(model[i][7:0]));
            hr(4'b1000, d);
            check(d == {8'((i + 1) % 256), 24'h0}, "R7", d, {8'((i + 1) % 256), 24'h0});
        end

        // R4: mask applied to written bytes
        hw(4'b0100, 32'h003C_0000);
        hw(4'b0001, 32'd40);
        wdata(8'hFF); wdata(8'h81); wdata(8'h5A);
        model[40] = {8'h3C, 8'h00, 8'h18};
        hw(4'b0100, 32'h00FF_0000);
        hr(4'b0100, d);
        check(d == 32'h00FF_0000, "R2", d, 32'h00FF_0000);
        hw(4'b1000, {8'd40, 24'h0});
        rcomp(c); check(c == 8'h3C, "R4", 32'(c), 32'h3C);
        rcomp(c); check(c == 8'h00, "R4", 32'(c), 32'h00);
        rcomp(c); check(c == 8'h18, "R4", 32'(c), 32'h18);

        // R3: index rewrite restarts the counter
        hw(4'b0001, 32'd50);
        wdata(8'h11);
        hw(4'b0001, 32'd50);
        wdata(8'h22); wdata(8'h33); wdata(8'h44);
        model[50] = 24'h223344;
        hr(4'b0001, d);
        check(d == 32'd51, "R3", d, 32'd51);
        hw(4'b1000, {8'd60, 24'h0});
        rcomp(c);
        hw(4'b1000, {8'd50, 24'h0});
        rcomp(c); check(c == 8'h22, "R3", 32'(c), 32'h22);
        rcomp(c); check(c == 8'h33, "R3", 32'(c), 32'h33);
        rcomp(c); check(c == 8'h44, "R3", 32'(c), 32'h44);

        // R3: data lane in the same write as an index lane is ignored
        hw(4'b0011, {16'h0, 8'h99, 8'd70});
        wdata(8'h01); wdata(8'h02); wdata(8'h03);
        model[70] = 24'h010203;
        hw(4'b1000, {8'd70, 24'h0});
        rcomp(c); check(c == 8'h01, "R3", 32'(c), 32'h01);
        rcomp(c); check(c == 8'h02, "R3", 32'(c), 32'h02);
        rcomp(c); check(c == 8'h03, "R3", 32'(c), 32'h03);

        // R1 R2: byte enables confine a write to its lanes
        hw(4'b0100, 32'h77F0_5533);
        hr(4'b1101, d);
        check(d == 32'h47F0_0047, "R1", d, 32'h47F0_0047);
        hr(4'b1111, d);
        check(d[31:16] == 16'h47F0 && d[7:0] == 8'h47, "R2", d, 32'h47F0_0047);

        // R9: pixel port sweep, with the mask moving between lookups
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            pix_idx = 8'(i);
            if (i % 16 == 0) begin
                wr_en = 1'b1; wr_be = 4'b0100; wr_data = {8'h0, 8'(i), 16'h0};
            end
            @(negedge clk);
            wr_en = 1'b0; wr_be = '0;
            check(pix_rgb == model[i], "R9", 32'(pix_rgb), 32'(model[i]));
        end

        finish_run();
    end
endmodule